// File: doc/BRIEF.md
# Dual Half-Bridge Fault Latch Controller

This block is the digital protection and reset controller for two pairs of half-bridges, called pair AB and pair CD. Each pair has two half-bridges, and each half-bridge has a PWM input, an overcurrent flag and a high-side and low-side gate enable. The other inputs are an active-low reset for each pair, one overtemperature flag and a static mode select. The mode select chooses between latching overcurrent shutdown and cycle-by-cycle limiting.

The way a fault clears depends on which protection tripped. A latched overcurrent clears on a rising edge of the affected pair's own reset. An overtemperature shutdown clears only after rising edges on both pair resets, and only once the temperature flag has dropped. In cycle-by-cycle mode an overcurrent swaps the conducting switch of that half-bridge for its complement until the next PWM cycle starts. While a pair is held in reset, its four switches are off and a weak pulldown lets the bootstrap capacitors charge.

Each pair reset passes through a two-flop synchronizer, and edges are detected on the synchronized value. Outputs respond to live fault flags in the same cycle.

Top module: `hb_fault_ctrl`

## Requirements
- R1: While rst_ni is low and just after it is released with both pair resets low, all gate enables are 0, both pulldown enables are 1 and fault_no is 1.
- R2: Two clock edges after a pair's reset input goes low, that pair's four gate enables are 0 and its pulldown enable is 1. This holds regardless of PWM or fault state. The other pair is unaffected.
- R3: With no fault and the pair out of reset, each half-bridge drives its high-side enable equal to its PWM input and its low-side enable equal to the inverse of its PWM input.
- R4: In latching mode (mode_cbc_i = 0), an overcurrent on any half-bridge of a pair turns off all four switches of that pair in the same cycle. It latches, and it drives fault_no low.
- R5: A latched overcurrent is cleared only by a rising edge of that pair's own synchronized reset, which also releases fault_no. An edge on the other pair's reset leaves the latch set.
- R6: If the overcurrent flag is still high when the clearing edge arrives, the latch stays set and fault_no stays low.
- R7: An overtemperature flag turns off every gate enable of both pairs in the same cycle, latches, and drives fault_no low.
- R8: The overtemperature latch clears only after rising edges on both synchronized pair resets, in either order, and only if ot_i is low. If both edges are seen while ot_i is high, they are discarded and two new edges are needed.
- R9: In cycle-by-cycle mode (mode_cbc_i = 1), an overcurrent turns off the conducting switch of that half-bridge and turns on its complement. Nothing latches, and fault_no stays high.
- R10: The cycle-by-cycle override of a half-bridge holds until the next rising edge of its PWM input. In that cycle normal PWM control resumes.
- R11: The high-side and low-side enables of one half-bridge are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| mode_cbc_i | input | 1 | Static mode: 0 latching overcurrent, 1 cycle-by-cycle |
| pwm_ab_i | input | HB_PER_PAIR | PWM per half-bridge of pair AB |
| pwm_cd_i | input | HB_PER_PAIR | PWM per half-bridge of pair CD |
| reset_ab_ni | input | 1 | Active-low reset of pair AB (asynchronous) |
| reset_cd_ni | input | 1 | Active-low reset of pair CD (asynchronous) |
| oc_ab_i | input | HB_PER_PAIR | Overcurrent flag per half-bridge of pair AB |
| oc_cd_i | input | HB_PER_PAIR | Overcurrent flag per half-bridge of pair CD |
| ot_i | input | 1 | Overtemperature flag |
| hs_ab_o | output | HB_PER_PAIR | High-side enables, pair AB |
| ls_ab_o | output | HB_PER_PAIR | Low-side enables, pair AB |
| hs_cd_o | output | HB_PER_PAIR | High-side enables, pair CD |
| ls_cd_o | output | HB_PER_PAIR | Low-side enables, pair CD |
| pd_ab_o | output | 1 | Weak pulldown enable, pair AB |
| pd_cd_o | output | 1 | Weak pulldown enable, pair CD |
| fault_no | output | 1 | Active-low fault flag |

## Verification
The directed cases each isolate one clearing rule:
- An overcurrent latch is pulsed with the wrong pair's reset and then with its own reset. This separates per-pair clearing from shared clearing.
- An overcurrent is held across its own clearing edge, which shows that setting takes priority over clearing.
- An overtemperature latch gets edges on one reset only, then edges on both while still hot, then edges in reverse order after cooling. This tells the "both edges" rule from an "any edge" rule, and stale edges from fresh ones.

In cycle-by-cycle mode, a trip with PWM held high, followed by a PWM low and a PWM rising edge, separates the override from both normal PWM and a latched shutdown. Random segments in both modes, with sparse faults and toggling resets, are compared every cycle against a bench model of the requirements.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;
  localparam int NUM_PAIRS = 2;
  localparam int PAIR_AB   = 0;
  localparam int PAIR_CD   = 1;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_CBC   = 1'b1
  } oc_mode_e;
endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hb_ot_latch.sv
module hb_ot_latch #(
  parameter int NP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ot_i,
  input  logic [NP-1:0] rise_i,
  output logic          lat_o
);
  logic          lat_q;
  logic [NP-1:0] seen_q;
  logic          all_seen;

  // every pair reset must have risen since the trip (or in this cycle)
  assign all_seen = &(seen_q | rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b0;
      seen_q <= '0;
    end else begin
      if (lat_q) begin
        if (all_seen) begin
          seen_q <= '0;          // consumed; still hot means new edges needed
          if (!ot_i) lat_q <= 1'b0;
        end else begin
          seen_q <= seen_q | rise_i;
        end
      end
      if (ot_i) lat_q <= 1'b1;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cbc_i,
  input  logic en_i,
  input  logic pwm_i,
  input  logic oc_i,
  output logic hs_o,
  output logic ls_o
);
  logic pwm_q;
  logic act_q;
  logic side_q;
  logic pwm_rise;
  logic trip;
  logic ovr;
  logic side_now;

  assign pwm_rise = pwm_i & ~pwm_q;
  assign trip     = cbc_i & oc_i;
  assign ovr      = trip | (act_q & ~pwm_rise);
  assign side_now = act_q ? side_q : pwm_i;   // 1: high side was conducting

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q  <= 1'b0;
      act_q  <= 1'b0;
      side_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      if (trip) begin
        act_q <= 1'b1;
        if (!act_q) side_q <= pwm_i;
      end else if (pwm_rise) begin
        act_q <= 1'b0;
      end
    end
  end

  assign hs_o = en_i & (ovr ? ~side_now : pwm_i);
  assign ls_o = en_i & (ovr ?  side_now : ~pwm_i);
endmodule

// File: rtl/hb_pair_ctrl.sv
module hb_pair_ctrl #(
  parameter int HB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cbc_i,
  input  logic          run_i,
  input  logic          rise_i,
  input  logic          ot_shut_i,
  input  logic [HB-1:0] pwm_i,
  input  logic [HB-1:0] oc_i,
  output logic [HB-1:0] hs_o,
  output logic [HB-1:0] ls_o,
  output logic          pd_o,
  output logic          oc_fault_o
);
  logic oc_lat_q;
  logic oc_live;
  logic en;

  assign oc_live = ~cbc_i & (|oc_i);

  // set wins over clear: an overcurrent present at the clearing edge stays latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oc_lat_q <= 1'b0;
    else if (oc_live)  oc_lat_q <= 1'b1;
    else if (rise_i)   oc_lat_q <= 1'b0;
  end

  assign en         = run_i & ~ot_shut_i & ~oc_lat_q & ~oc_live;
  assign pd_o       = ~run_i;
  assign oc_fault_o = oc_lat_q | oc_live;

  for (genvar h = 0; h < HB; h++) begin : g_leg
    hb_leg u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cbc_i  (cbc_i),
      .en_i   (en),
      .pwm_i  (pwm_i[h]),
      .oc_i   (oc_i[h]),
      .hs_o   (hs_o[h]),
      .ls_o   (ls_o[h])
    );
  end
endmodule

// File: rtl/hb_fault_ctrl.sv
module hb_fault_ctrl
  import hb_fault_pkg::*;
#(
  parameter int HB_PER_PAIR = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_cbc_i,
  input  logic [HB_PER_PAIR-1:0] pwm_ab_i,
  input  logic [HB_PER_PAIR-1:0] pwm_cd_i,
  input  logic                   reset_ab_ni,
  input  logic                   reset_cd_ni,
  input  logic [HB_PER_PAIR-1:0] oc_ab_i,
  input  logic [HB_PER_PAIR-1:0] oc_cd_i,
  input  logic                   ot_i,
  output logic [HB_PER_PAIR-1:0] hs_ab_o,
  output logic [HB_PER_PAIR-1:0] ls_ab_o,
  output logic [HB_PER_PAIR-1:0] hs_cd_o,
  output logic [HB_PER_PAIR-1:0] ls_cd_o,
  output logic                   pd_ab_o,
  output logic                   pd_cd_o,
  output logic                   fault_no
);
  localparam int HB = HB_PER_PAIR;

  oc_mode_e                      mode;
  logic [NUM_PAIRS-1:0]          prst_n;
  logic [NUM_PAIRS-1:0]          run;
  logic [NUM_PAIRS-1:0]          rise;
  logic [NUM_PAIRS-1:0]          pd;
  logic [NUM_PAIRS-1:0]          oc_fault;
  logic [NUM_PAIRS-1:0][HB-1:0]  pwm;
  logic [NUM_PAIRS-1:0][HB-1:0]  oc;
  logic [NUM_PAIRS-1:0][HB-1:0]  hs;
  logic [NUM_PAIRS-1:0][HB-1:0]  ls;
  logic                          ot_lat;
  logic                          ot_shut;

  assign mode             = oc_mode_e'(mode_cbc_i);
  assign prst_n[PAIR_AB]  = reset_ab_ni;
  assign prst_n[PAIR_CD]  = reset_cd_ni;
  assign pwm[PAIR_AB]     = pwm_ab_i;
  assign pwm[PAIR_CD]     = pwm_cd_i;
  assign oc[PAIR_AB]      = oc_ab_i;
  assign oc[PAIR_CD]      = oc_cd_i;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    hb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (prst_n[p]),
      .q_o    (run[p]),
      .rise_o (rise[p])
    );

    hb_pair_ctrl #(.HB(HB)) u_pair (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cbc_i      (mode == MODE_CBC),
      .run_i      (run[p]),
      .rise_i     (rise[p]),
      .ot_shut_i  (ot_shut),
      .pwm_i      (pwm[p]),
      .oc_i       (oc[p]),
      .hs_o       (hs[p]),
      .ls_o       (ls[p]),
      .pd_o       (pd[p]),
      .oc_fault_o (oc_fault[p])
    );
  end

  hb_ot_latch #(.NP(NUM_PAIRS)) u_ot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ot_i   (ot_i),
    .rise_i (rise),
    .lat_o  (ot_lat)
  );

  assign ot_shut  = ot_lat | ot_i;

  assign hs_ab_o  = hs[PAIR_AB];
  assign ls_ab_o  = ls[PAIR_AB];
  assign hs_cd_o  = hs[PAIR_CD];
  assign ls_cd_o  = ls[PAIR_CD];
  assign pd_ab_o  = pd[PAIR_AB];
  assign pd_cd_o  = pd[PAIR_CD];
  assign fault_no = ~(ot_shut | (|oc_fault));
endmodule

// File: rtl/hb_fault_chk.sv
module hb_fault_chk #(
  parameter int HB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_cbc_i,
  input logic          reset_ab_ni,
  input logic          reset_cd_ni,
  input logic [HB-1:0] oc_ab_i,
  input logic [HB-1:0] oc_cd_i,
  input logic          ot_i,
  input logic [HB-1:0] hs_ab_o,
  input logic [HB-1:0] ls_ab_o,
  input logic [HB-1:0] hs_cd_o,
  input logic [HB-1:0] ls_cd_o,
  input logic          pd_ab_o,
  input logic          pd_cd_o,
  input logic          fault_no
);
  // R11
  excl_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ab_o & ls_ab_o) == '0);

  // R11
  excl_cd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_cd_o & ls_cd_o) == '0);

  // R2
  rst_ab_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_ab_ni && $past(!reset_ab_ni) && $past(!reset_ab_ni, 2))
      |-> (hs_ab_o == '0 && ls_ab_o == '0 && pd_ab_o));

  // R2
  pd_ab_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_ab_o |-> (hs_ab_o == '0 && ls_ab_o == '0));

  // R2
  pd_cd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_cd_o |-> (hs_cd_o == '0 && ls_cd_o == '0));

  // R7
  ot_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> (!fault_no && hs_ab_o == '0 && ls_ab_o == '0 &&
              hs_cd_o == '0 && ls_cd_o == '0));

  // R4
  oc_ab_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_cbc_i && |oc_ab_i) |-> (!fault_no && hs_ab_o == '0 && ls_ab_o == '0));

  // R4
  oc_ab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_cbc_i && $past(!mode_cbc_i) && $past(|oc_ab_i) && $past(rst_ni) && reset_ab_ni
     && $past(reset_ab_ni)) |-> !fault_no);
endmodule

bind hb_fault_ctrl hb_fault_chk #(.HB(HB_PER_PAIR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_cbc_i  (mode_cbc_i),
  .reset_ab_ni (reset_ab_ni),
  .reset_cd_ni (reset_cd_ni),
  .oc_ab_i     (oc_ab_i),
  .oc_cd_i     (oc_cd_i),
  .ot_i        (ot_i),
  .hs_ab_o     (hs_ab_o),
  .ls_ab_o     (ls_ab_o),
  .hs_cd_o     (hs_cd_o),
  .ls_cd_o     (ls_cd_o),
  .pd_ab_o     (pd_ab_o),
  .pd_cd_o     (pd_cd_o),
  .fault_no    (fault_no)
);

// File: tb/hb_fault_ctrl_tb.sv
module hb_fault_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_cbc_i = 1'b0;
  logic [1:0] pwm_ab_i = '0, pwm_cd_i = '0, oc_ab_i = '0, oc_cd_i = '0;
  logic       reset_ab_ni = 1'b0, reset_cd_ni = 1'b0, ot_i = 1'b0;
  logic [1:0] hs_ab_o, ls_ab_o, hs_cd_o, ls_cd_o;
  logic       pd_ab_o, pd_cd_o, fault_no;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;
  bit  model_on = 1'b1;

  always #4 clk_i = ~clk_i;   // 125 MHz

  hb_fault_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_cbc_i(mode_cbc_i),
    .pwm_ab_i(pwm_ab_i), .pwm_cd_i(pwm_cd_i),
    .reset_ab_ni(reset_ab_ni), .reset_cd_ni(reset_cd_ni),
    .oc_ab_i(oc_ab_i), .oc_cd_i(oc_cd_i), .ot_i(ot_i),
    .hs_ab_o(hs_ab_o), .ls_ab_o(ls_ab_o), .hs_cd_o(hs_cd_o), .ls_cd_o(ls_cd_o),
    .pd_ab_o(pd_ab_o), .pd_cd_o(pd_cd_o), .fault_no(fault_no)
  );

  // ---------------- reference model of the requirements ----------------
  logic [1:0] m_s0, m_s1, m_prev, m_oc, m_seen;
  logic       m_ot;
  logic [1:0][1:0] m_act, m_side, m_pq;

  function automatic logic [1:0] pair_rst(input int p);
    return (p == 0) ? reset_ab_ni : reset_cd_ni;
  endfunction
  function automatic logic [1:0] pair_oc(input int p);
    return (p == 0) ? oc_ab_i : oc_cd_i;
  endfunction
  function automatic logic [1:0] pair_pwm(input int p);
    return (p == 0) ? pwm_ab_i : pwm_cd_i;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s0 = '0; m_s1 = '0; m_prev = '0; m_oc = '0; m_seen = '0; m_ot = 1'b0;
      m_act = '0; m_side = '0; m_pq = '0;
    end else begin
      logic [1:0] rise;
      logic       both;
      rise = m_s1 & ~m_prev;
      for (int p = 0; p < 2; p++) begin
        if (!mode_cbc_i && |pair_oc(p)) m_oc[p] = 1'b1;
        else if (rise[p])               m_oc[p] = 1'b0;
        for (int h = 0; h < 2; h++) begin
          logic trip, prise, pw;
          pw    = pair_pwm(p)[h];
          trip  = mode_cbc_i & pair_oc(p)[h];
          prise = pw & ~m_pq[p][h];
          if (trip) begin
            if (!m_act[p][h]) m_side[p][h] = pw;
            m_act[p][h] = 1'b1;
          end else if (prise) m_act[p][h] = 1'b0;
          m_pq[p][h] = pw;
        end
      end
      both = (m_seen[0] | rise[0]) & (m_seen[1] | rise[1]);
      if (m_ot) begin
        if (both) begin
          m_seen = '0;
          if (!ot_i) m_ot = 1'b0;
        end else m_seen = m_seen | rise;
      end
      if (ot_i) m_ot = 1'b1;
      m_prev = m_s1;
      m_s1   = m_s0;
      m_s0   = {reset_cd_ni, reset_ab_ni};
    end
  end

  function automatic logic [10:0] expect_out();
    logic [1:0][1:0] hs, ls;
    logic live_any;
    live_any = !mode_cbc_i && (|oc_ab_i || |oc_cd_i);
    for (int p = 0; p < 2; p++) begin
      logic en;
      en = m_s1[p] & ~m_ot & ~ot_i & ~m_oc[p] & ~(!mode_cbc_i && |pair_oc(p));
      for (int h = 0; h < 2; h++) begin
        logic pw, trip, ovr, sn;
        pw   = pair_pwm(p)[h];
        trip = mode_cbc_i & pair_oc(p)[h];
        ovr  = trip | (m_act[p][h] & ~(pw & ~m_pq[p][h]));
        sn   = m_act[p][h] ? m_side[p][h] : pw;
        hs[p][h] = en & (ovr ? ~sn : pw);
        ls[p][h] = en & (ovr ? sn : ~pw);
      end
    end
    return {hs[0], ls[0], hs[1], ls[1], ~m_s1[0], ~m_s1[1],
            ~(m_oc[0] | m_oc[1] | m_ot | ot_i | live_any)};
  endfunction

  function automatic logic [10:0] actual_out();
    return {hs_ab_o, ls_ab_o, hs_cd_o, ls_cd_o, pd_ab_o, pd_cd_o, fault_no};
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle model comparison, away from the clock edge
  always @(negedge clk_i) begin
    #3;
    if (rst_ni && model_on && !done) begin
      chk("R3", actual_out(), expect_out());
      chk("R11", 11'((hs_ab_o & ls_ab_o) | (hs_cd_o & ls_cd_o)), 11'd0);
    end
  end

  task automatic adv(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse_rst(input bit ab);
    adv(1);
    if (ab) reset_ab_ni = 1'b0; else reset_cd_ni = 1'b0;
    adv(3);
    if (ab) reset_ab_ni = 1'b1; else reset_cd_ni = 1'b1;
    adv(4);
  endtask

  task automatic restart(input logic mode);
    adv(1);
    rst_ni = 1'b0; reset_ab_ni = 1'b1; reset_cd_ni = 1'b1;
    oc_ab_i = '0; oc_cd_i = '0; ot_i = 1'b0; mode_cbc_i = mode;
    adv(2);
    rst_ni = 1'b1;
    adv(4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    adv(2); settle();
    chk("R1", actual_out(), {8'h00, 3'b111});
    rst_ni = 1'b1;
    adv(3); settle();
    chk("R1", actual_out(), {8'h00, 3'b111});

    // R3 normal PWM
    reset_ab_ni = 1'b1; reset_cd_ni = 1'b1;
    pwm_ab_i = 2'b01; pwm_cd_i = 2'b10;
    adv(4); settle();
    chk("R3", actual_out(), {2'b01, 2'b10, 2'b10, 2'b01, 3'b001});

    // R2 pair reset low, other pair unaffected
    reset_ab_ni = 1'b0;
    adv(3); settle();
    chk("R2", actual_out(), {2'b00, 2'b00, 2'b10, 2'b01, 3'b101});
    reset_ab_ni = 1'b1;
    adv(4);

    // R4 latching overcurrent on AB
    oc_ab_i = 2'b10; settle();
    chk("R4", actual_out(), {2'b00, 2'b00, 2'b10, 2'b01, 3'b000});
    adv(1); oc_ab_i = 2'b00;
    adv(2); settle();
    chk("R4", actual_out(), {2'b00, 2'b00, 2'b10, 2'b01, 3'b000});

    // R5 other pair's reset does not clear, own reset does
    pulse_rst(1'b0); settle();
    chk("R5", actual_out(), {2'b00, 2'b00, 2'b10, 2'b01, 3'b000});
    pulse_rst(1'b1); settle();
    chk("R5", actual_out(), {2'b01, 2'b10, 2'b10, 2'b01, 3'b001});

    // R6 overcurrent held across the clearing edge
    oc_ab_i = 2'b01;
    pulse_rst(1'b1);
    oc_ab_i = 2'b00; settle();
    chk("R6", actual_out(), {2'b00, 2'b00, 2'b10, 2'b01, 3'b000});
    pulse_rst(1'b1); settle();
    chk("R6", actual_out(), {2'b01, 2'b10, 2'b10, 2'b01, 3'b001});

    // R7 overtemperature
    ot_i = 1'b1; settle();
    chk("R7", actual_out(), {8'h00, 3'b000});
    adv(1); ot_i = 1'b0;
    adv(2); settle();
    chk("R7", actual_out(), {8'h00, 3'b000});

    // R8 one reset is not enough
    pulse_rst(1'b1); settle();
    chk("R8", actual_out(), {8'h00, 3'b000});
    pulse_rst(1'b0); settle();
    chk("R8", actual_out(), {2'b01, 2'b10, 2'b10, 2'b01, 3'b001});
    // R8 both edges while hot are discarded
    ot_i = 1'b1;
    pulse_rst(1'b1);
    pulse_rst(1'b0);
    ot_i = 1'b0;
    adv(3); settle();
    chk("R8", actual_out(), {8'h00, 3'b000});
    pulse_rst(1'b0);
    pulse_rst(1'b1); settle();
    chk("R8", actual_out(), {2'b01, 2'b10, 2'b10, 2'b01, 3'b001});

    // R9 / R10 cycle-by-cycle mode
    restart(1'b1);
    pwm_ab_i = 2'b01; pwm_cd_i = 2'b00;
    adv(2); settle();
    chk("R3", actual_out(), {2'b01, 2'b10, 2'b00, 2'b11, 3'b001});
    oc_ab_i = 2'b01; settle();
    chk("R9", actual_out(), {2'b00, 2'b11, 2'b00, 2'b11, 3'b001});
    adv(1); oc_ab_i = 2'b00; settle();
    chk("R10", actual_out(), {2'b00, 2'b11, 2'b00, 2'b11, 3'b001});
    adv(1); pwm_ab_i = 2'b00; settle();
    chk("R10", actual_out(), {2'b00, 2'b11, 2'b00, 2'b11, 3'b001});
    adv(1); pwm_ab_i = 2'b01; settle();
    chk("R10", actual_out(), {2'b01, 2'b10, 2'b00, 2'b11, 3'b001});

    // constrained random segments in both modes
    for (int seg = 0; seg < 8; seg++) begin
      restart(logic'(seg % 2));
      for (int c = 0; c < 600; c++) begin
        adv(1);
        for (int h = 0; h < 2; h++) begin
          if ($urandom % 4 == 0) pwm_ab_i[h] = ~pwm_ab_i[h];
          if ($urandom % 4 == 0) pwm_cd_i[h] = ~pwm_cd_i[h];
          oc_ab_i[h] = ($urandom % 40 == 0);
          oc_cd_i[h] = ($urandom % 40 == 0);
        end
        ot_i = ($urandom % 150 == 0);
        if ($urandom % 24 == 0) reset_ab_ni = ~reset_ab_ni;
        if ($urandom % 24 == 0) reset_cd_ni = ~reset_cd_ni;
      end
    end

    adv(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule